// File: doc/BRIEF.md
# Three-Phase Modulation Reference Generator with Zero-Sequence Injection

This block produces the three sinusoidal modulation references that drive a carrier-based PWM stage. The references are signed fixed-point values, spaced a third of a turn apart. A phase accumulator advances by a frequency tuning word on every sample strobe. Each reference is the sine of its phase scaled by a modulation index. The same zero-sequence term is added to all three references. The line-to-line voltages therefore keep their shape, and the per-phase waveform is flattened. This lowers output current ripple and the current drawn from the DC-link midpoint of a three-level stage.

A mode input selects the injected term. It can be nothing, a third harmonic at one quarter or one sixth of the index, or a form that adapts to the load power factor. The adaptive form mixes the sine and cosine of three times the angle, weighted by the cosine and sine of the load angle. The caller supplies those two values already computed. The third-harmonic angle is taken from the same accumulator, so the harmonic stays phase-locked to the fundamental. Sine values come from a quarter-wave table that is built when the design is elaborated.

With the default 32-bit accumulator and a 10 kHz sample strobe, 50 Hz needs a tuning word of 21474836.

Top module: `tri_ref_gen`

## Requirements
- R1: While reset is held low at a clock edge, the three references become 0 and valid becomes low. The phase accumulator also clears, so the first sample after reset uses phase 0.
- R2: Each clock edge with sample_en_i high uses the current phase and then advances the phase by tune_i. The phase wraps modulo 2^PHASE_W, and 2^PHASE_W stands for one full turn.
- R3: At an edge with sample_en_i low, the references and the phase keep their values.
- R4: valid_o is high in exactly the cycle that follows each edge with sample_en_i high, and low in every other cycle.
- R5: Scaling is Q1.15. k_i is unsigned, and 32768 means 1.0; larger values act as 1.0. A reference of 32767 means full scale. With mode 0 (no injection), ref_u = k·sin θ, ref_v = k·sin(θ − 2π/3) and ref_w = k·sin(θ + 2π/3).
- R6: Mode 1 adds (k/4)·sin 3θ to all three references. The 3θ angle is three times the accumulator phase, modulo one turn.
- R7: Mode 2 adds (k/6)·sin 3θ to all three references.
- R8: Mode 3 adds (k/(5π))·(4·cosφ·sin 3θ − 6·sinφ·cos 3θ) to all three references. cosφ and sinφ are signed Q1.15 inputs. With cosφ = 1 and sinφ = 0 this form is close to the mode 1 term.
- R9: The sum of fundamental and injection saturates to the range [−32767, +32767]. The code −32768 never appears.
- R10: When k_i is 0, all three references are exactly 0 in every mode.
- R11: Each reference lies within 300 LSB of the ideal real-valued result of R5 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en_i | input | 1 | Sample strobe: update references, advance phase |
| tune_i | input | PHASE_W | Phase increment per sample |
| k_i | input | K_W | Modulation index, unsigned, 2^(K_W-1) = 1.0 |
| inj_mode_i | input | 2 | 0 none, 1 quarter, 2 sixth, 3 power-factor adaptive |
| cos_phi_i | input | DATA_W | Cosine of load angle, signed Q1.15 |
| sin_phi_i | input | DATA_W | Sine of load angle, signed Q1.15 |
| ref_u_o | output | DATA_W | Phase u reference, signed |
| ref_v_o | output | DATA_W | Phase v reference (lags u by 2π/3), signed |
| ref_w_o | output | DATA_W | Phase w reference (leads u by 2π/3), signed |
| valid_o | output | 1 | High for one cycle after each update |

## Verification
Some rules are checked by the assertions on every clock edge:
- the accumulator steps by the tuning word on a strobe and holds otherwise;
- the references stay unchanged when no strobe is present;
- valid follows the strobe;
- a zero index gives zero outputs;
- the code −32768 never appears.

The waveforms themselves can only be shown by the bench's scenarios. These cover the phase offsets, each injection shape, the effect of the load angle, clamping of the index, and saturation at the peaks. The bench sweeps more than a full turn of phase in every mode and compares each sample with a real-valued model.

// File: rtl/tri_ref_pkg.sv
// Shared definitions for the three-phase reference generator.
// Assumes: the injection mode code is two bits wide and fixed in value.
package tri_ref_pkg;

    typedef enum logic [1:0] {
        INJ_NONE    = 2'd0,
        INJ_QUARTER = 2'd1,
        INJ_SIXTH   = 2'd2,
        INJ_PFADAPT = 2'd3
    } inj_mode_e;

    localparam real TWO_PI_CONST = 6.283185307179586;

endpackage

// File: rtl/tri_ref_phase.sv
// Phase accumulator. Also produces the phase angles of the three outputs
// and the 3x angle (plus its quarter-turn copy, used for the cosine).
// Assumes: one full turn equals 2^PHASE_W; the offsets are truncated thirds of a turn.
module tri_ref_phase #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_en_i,
    input  logic [PHASE_W-1:0] tune_i,
    output logic [PHASE_W-1:0] ph_u_o,
    output logic [PHASE_W-1:0] ph_v_o,
    output logic [PHASE_W-1:0] ph_w_o,
    output logic [PHASE_W-1:0] ph_3_o,
    output logic [PHASE_W-1:0] ph_3q_o
);

    localparam logic [PHASE_W:0]   TURN    = {1'b1, {PHASE_W{1'b0}}};
    localparam logic [PHASE_W-1:0] THIRD   = PHASE_W'(TURN / 3);
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(TURN >> 2);

    logic [PHASE_W-1:0] acc;

    // Advance the phase once per sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (sample_en_i) begin
            acc <= acc + tune_i;
        end
    end

    // Derive the per-phase angles and the third-harmonic angle
    always_comb begin
        ph_u_o  = acc;
        ph_v_o  = acc - THIRD;
        ph_w_o  = acc + THIRD;
        ph_3_o  = acc + (acc << 1);
        ph_3q_o = ph_3_o + QUARTER;
    end

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_i |=> (acc == $past(acc) + $past(tune_i))); // R2
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en_i |=> $stable(acc)); // R3

endmodule

// File: rtl/tri_ref_sine.sv
// Sine lookup from a quarter-wave magnitude table that is computed at elaboration.
// Entries are taken at bin centres, so mirroring by inverting the index is exact.
// Assumes: PHASE_W >= LUT_ABITS + 2; the output is symmetric within +/-(2^(DATA_W-1)-1).
module tri_ref_sine #(
    parameter int PHASE_W   = 32,
    parameter int DATA_W    = 16,
    parameter int LUT_ABITS = 8
) (
    input  logic [PHASE_W-1:0]        phase_i,
    output logic signed [DATA_W-1:0]  sin_o
);

    localparam int  ENTRIES = 1 << LUT_ABITS;
    localparam int  AMP     = (1 << (DATA_W - 1)) - 1;
    localparam int  TOP_W   = LUT_ABITS + 2;

    logic [DATA_W-2:0]    mag_tab [ENTRIES];
    logic [TOP_W-1:0]     top_bits;
    logic [1:0]           quad;
    logic [LUT_ABITS-1:0] idx;
    logic [LUT_ABITS-1:0] addr;
    logic signed [DATA_W-1:0] mag_s;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_tab
        localparam real ANG = (real'(i) + 0.5) * tri_ref_pkg::TWO_PI_CONST / (4.0 * real'(ENTRIES));
        localparam int  VAL = $rtoi($sin(ANG) * real'(AMP) + 0.5);
        assign mag_tab[i] = (DATA_W-1)'(VAL);
    end

    // Fold the angle into the first quadrant and restore the sign
    always_comb begin
        top_bits = TOP_W'(phase_i >> (PHASE_W - TOP_W));
        quad     = top_bits[TOP_W-1 -: 2];
        idx      = top_bits[LUT_ABITS-1:0];
        addr     = quad[0] ? ~idx : idx;
        mag_s    = $signed({1'b0, mag_tab[addr]});
        sin_o    = quad[1] ? -mag_s : mag_s;
    end

endmodule

// File: rtl/tri_ref_inject.sv
// Computes the zero-sequence term that is shared by all three phases.
// Assumes: Q1.(DATA_W-1) signals, k_eff_i <= 2^(K_W-1), and a mode code
// decoded as in tri_ref_pkg.
module tri_ref_inject
    import tri_ref_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int K_W    = 16
) (
    input  logic [K_W-1:0]           k_eff_i,
    input  logic [1:0]               mode_i,
    input  logic signed [DATA_W-1:0] sin3_i,
    input  logic signed [DATA_W-1:0] cos3_i,
    input  logic signed [DATA_W-1:0] cos_phi_i,
    input  logic signed [DATA_W-1:0] sin_phi_i,
    output logic signed [DATA_W:0]   s0_o
);

    localparam int  F    = DATA_W - 1;
    localparam int  KF   = K_W - 1;
    localparam int  MW   = DATA_W + K_W + 4;
    localparam real PI_R = TWO_PI_CONST / 2.0;
    localparam int  C6   = $rtoi(real'(1 << F) / 6.0 + 0.5);
    localparam int  CA   = $rtoi(4.0 / (5.0 * PI_R) * real'(1 << F) + 0.5);
    localparam int  CB   = $rtoi(6.0 / (5.0 * PI_R) * real'(1 << F) + 0.5);
    localparam logic signed [MW-1:0] C6_S = MW'(C6);
    localparam logic signed [MW-1:0] CA_S = MW'(CA);
    localparam logic signed [MW-1:0] CB_S = MW'(CB);

    logic signed [K_W:0]    k_s;
    logic signed [MW-1:0]   p_h, p_a, p_b, p_mix, p_pf, p_6;
    logic signed [DATA_W:0] harm, term_a, term_b, mix, pf_val, six_val;

    // Form every candidate term in fixed point
    always_comb begin
        k_s     = $signed({1'b0, k_eff_i});
        p_h     = MW'(k_s) * MW'(sin3_i);
        harm    = (DATA_W+1)'(p_h >>> KF);
        p_6     = MW'(harm) * C6_S;
        six_val = (DATA_W+1)'(p_6 >>> F);
        p_a     = MW'(cos_phi_i) * MW'(sin3_i);
        term_a  = (DATA_W+1)'(p_a >>> F);
        p_b     = MW'(sin_phi_i) * MW'(cos3_i);
        term_b  = (DATA_W+1)'(p_b >>> F);
        p_mix   = MW'(term_a) * CA_S - MW'(term_b) * CB_S;
        mix     = (DATA_W+1)'(p_mix >>> F);
        p_pf    = MW'(k_s) * MW'(mix);
        pf_val  = (DATA_W+1)'(p_pf >>> KF);
    end

    // Select the term called for by the mode
    always_comb begin
        case (inj_mode_e'(mode_i))
            INJ_QUARTER: s0_o = harm >>> 2;
            INJ_SIXTH:   s0_o = six_val;
            INJ_PFADAPT: s0_o = pf_val;
            default:     s0_o = '0;
        endcase
    end

endmodule

// File: rtl/tri_ref_mix.sv
// Scales one phase sine by the index, adds the shared injection term and
// saturates the sum to the symmetric full-scale range.
// Assumes: Q1.(DATA_W-1) signals and k_eff_i <= 2^(K_W-1).
module tri_ref_mix #(
    parameter int DATA_W = 16,
    parameter int K_W    = 16
) (
    input  logic [K_W-1:0]           k_eff_i,
    input  logic signed [DATA_W-1:0] sin_i,
    input  logic signed [DATA_W:0]   s0_i,
    output logic signed [DATA_W-1:0] ref_o
);

    localparam int KF = K_W - 1;
    localparam int MW = DATA_W + K_W + 4;
    localparam logic signed [DATA_W+1:0] SAT_HI = (DATA_W+2)'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [DATA_W+1:0] SAT_LO = -SAT_HI;

    logic signed [MW-1:0]     p_f;
    logic signed [DATA_W+1:0] fund, tot;

    // Scale, add and clamp
    always_comb begin
        p_f  = MW'($signed({1'b0, k_eff_i})) * MW'(sin_i);
        fund = (DATA_W+2)'(p_f >>> KF);
        tot  = fund + (DATA_W+2)'(s0_i);
        if (tot > SAT_HI) begin
            ref_o = DATA_W'(SAT_HI);
        end else if (tot < SAT_LO) begin
            ref_o = DATA_W'(SAT_LO);
        end else begin
            ref_o = DATA_W'(tot);
        end
    end

endmodule

// File: rtl/tri_ref_gen.sv
// Top level of the three-phase reference generator. It clamps the index, looks up
// five sines (three phases, sin 3θ, cos 3θ), adds the shared injection term and
// registers the three references on the sample strobe.
// Assumes: synchronous active-low reset; the caller supplies cosφ and sinφ already computed.
module tri_ref_gen #(
    parameter int PHASE_W   = 32,
    parameter int DATA_W    = 16,
    parameter int K_W       = 16,
    parameter int LUT_ABITS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_en_i,
    input  logic [PHASE_W-1:0]       tune_i,
    input  logic [K_W-1:0]           k_i,
    input  logic [1:0]               inj_mode_i,
    input  logic signed [DATA_W-1:0] cos_phi_i,
    input  logic signed [DATA_W-1:0] sin_phi_i,
    output logic signed [DATA_W-1:0] ref_u_o,
    output logic signed [DATA_W-1:0] ref_v_o,
    output logic signed [DATA_W-1:0] ref_w_o,
    output logic                     valid_o
);

    localparam int N_LOOKUPS = 5;
    localparam int N_PHASES  = 3;
    localparam logic [K_W-1:0] K_ONE = K_W'(1) << (K_W - 1);
    localparam logic signed [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [K_W-1:0]           k_eff;
    logic [PHASE_W-1:0]       ph   [N_LOOKUPS];
    logic signed [DATA_W-1:0] sv   [N_LOOKUPS];
    logic signed [DATA_W-1:0] mixed[N_PHASES];
    logic signed [DATA_W:0]   s0;

    // Limit the modulation index to 1.0
    always_comb begin
        k_eff = (k_i > K_ONE) ? K_ONE : k_i;
    end

    tri_ref_phase #(.PHASE_W(PHASE_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en_i (sample_en_i),
        .tune_i      (tune_i),
        .ph_u_o      (ph[0]),
        .ph_v_o      (ph[1]),
        .ph_w_o      (ph[2]),
        .ph_3_o      (ph[3]),
        .ph_3q_o     (ph[4])
    );

    for (genvar g = 0; g < N_LOOKUPS; g++) begin : g_sine
        tri_ref_sine #(.PHASE_W(PHASE_W), .DATA_W(DATA_W), .LUT_ABITS(LUT_ABITS)) u_sine (
            .phase_i (ph[g]),
            .sin_o   (sv[g])
        );
    end

    tri_ref_inject #(.DATA_W(DATA_W), .K_W(K_W)) u_inject (
        .k_eff_i   (k_eff),
        .mode_i    (inj_mode_i),
        .sin3_i    (sv[3]),
        .cos3_i    (sv[4]),
        .cos_phi_i (cos_phi_i),
        .sin_phi_i (sin_phi_i),
        .s0_o      (s0)
    );

    for (genvar g = 0; g < N_PHASES; g++) begin : g_mix
        tri_ref_mix #(.DATA_W(DATA_W), .K_W(K_W)) u_mix (
            .k_eff_i (k_eff),
            .sin_i   (sv[g]),
            .s0_i    (s0),
            .ref_o   (mixed[g])
        );
    end

    // Register the references on the strobe and flag them one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_u_o <= '0;
            ref_v_o <= '0;
            ref_w_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= sample_en_i;
            if (sample_en_i) begin
                ref_u_o <= mixed[0];
                ref_v_o <= mixed[1];
                ref_w_o <= mixed[2];
            end
        end
    end

    AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_i |=> valid_o); // R4
    AST_VALID_ONLY_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en_i |=> !valid_o); // R4
    AST_HOLD_REFS: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en_i |=> ($stable(ref_u_o) && $stable(ref_v_o) && $stable(ref_w_o))); // R3
    AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en_i && (k_i == '0)) |=> (ref_u_o == '0 && ref_v_o == '0 && ref_w_o == '0)); // R10
    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_u_o != MIN_CODE && ref_v_o != MIN_CODE && ref_w_o != MIN_CODE)); // R9

endmodule

// File: tb/sim_tri_ref_gen.sv
`timescale 1ns/1ps
module sim_tri_ref_gen;

    localparam int  TOL   = 300;
    localparam real TWOPI = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic [31:0] tune = '0;
    logic [15:0] k = '0;
    logic [1:0]  mode = '0;
    logic signed [15:0] cphi = '0, sphi = '0;
    logic signed [15:0] ref_u, ref_v, ref_w;
    logic        valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    tri_ref_gen u0 (
        .clk(clk), .rst_n(rst_n), .sample_en_i(sample_en), .tune_i(tune),
        .k_i(k), .inj_mode_i(mode), .cos_phi_i(cphi), .sin_phi_i(sphi),
        .ref_u_o(ref_u), .ref_v_o(ref_v), .ref_w_o(ref_w), .valid_o(valid)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    // Ideal reference for phase index 0 (u), 1 (v) or 2 (w)
    function automatic int ideal(input logic [31:0] p, input int idx, input int md,
                                 input int kk, input int cp, input int sp);
        real kr, th, off, fund, s0, tot;
        kr  = ((kk > 32768) ? 32768.0 : real'(kk)) / 32768.0;
        th  = TWOPI * real'(p) / 4294967296.0;
        off = (idx == 0) ? 0.0 : ((idx == 1) ? -TWOPI / 3.0 : TWOPI / 3.0);
        fund = kr * $sin(th + off);
        case (md)
            1: s0 = kr / 4.0 * $sin(3.0 * th);
            2: s0 = kr / 6.0 * $sin(3.0 * th);
            3: s0 = kr / (5.0 * TWOPI / 2.0) *
                    (4.0 * (real'(cp) / 32768.0) * $sin(3.0 * th)
                   - 6.0 * (real'(sp) / 32768.0) * $cos(3.0 * th));
            default: s0 = 0.0;
        endcase
        tot = (fund + s0) * 32767.0;
        if (tot > 32767.0) tot = 32767.0;
        if (tot < -32767.0) tot = -32767.0;
        return rnd(tot);
    endfunction

    function automatic int got(input int idx);
        return (idx == 0) ? int'(ref_u) : ((idx == 1) ? int'(ref_v) : int'(ref_w));
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_sample();
        @(negedge clk) sample_en = 1'b1;
        @(negedge clk) sample_en = 1'b0;
    endtask

    // Reset, apply one configuration and compare a run of samples with the model
    task automatic run_cfg(input int md, input int kk, input int cp, input int sp,
                           input logic [31:0] tw, input int n, input int tol,
                           input string req, output int sat_hits);
        logic [31:0] p;
        int exp_v, act_v, diff;
        int hold[3];
        do_reset();
        mode = 2'(md); k = 16'(kk); cphi = 16'(cp); sphi = 16'(sp); tune = tw;
        p = '0;
        sat_hits = 0;
        for (int i = 0; i < n; i++) begin
            do_sample();
            chk(valid == 1'b1, "R4", int'(valid), 1);
            for (int ph = 0; ph < 3; ph++) begin
                exp_v = ideal(p, ph, md, kk, cp, sp);
                act_v = got(ph);
                diff  = (act_v > exp_v) ? act_v - exp_v : exp_v - act_v;
                chk(diff <= tol && act_v != -32768, req, act_v, exp_v);
                if (act_v == 32767 || act_v == -32767) sat_hits++;
            end
            p = p + tw;
            if (i % 64 == 63) begin
                // R3: idle cycles leave outputs untouched; R4: valid stays low
                for (int ph = 0; ph < 3; ph++) hold[ph] = got(ph);
                repeat (3) @(negedge clk);
                chk(valid == 1'b0, "R4", int'(valid), 0);
                for (int ph = 0; ph < 3; ph++) chk(got(ph) == hold[ph], "R3", got(ph), hold[ph]);
            end
        end
    endtask

    initial begin
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state after the first reset
        do_reset();
        chk(ref_u == 0 && ref_v == 0 && ref_w == 0, "R1", int'(ref_u), 0);
        chk(valid == 1'b0, "R1", int'(valid), 0);

        // R2: quarter-turn steps from phase 0, wrapping twice
        run_cfg(0, 32768, 0, 0, 32'h4000_0000, 9, TOL, "R2", hits);
        // R5: plain sinusoids at several indices, including a clamped index
        run_cfg(0, 32768, 0, 0, 32'h0123_4567, 300, TOL, "R5", hits);
        run_cfg(0, 13107, 0, 0, 32'h0123_4567, 200, TOL, "R5", hits);
        run_cfg(0, 65535, 0, 0, 32'h0234_5679, 200, TOL, "R5", hits);
        // R6 and R7: third-harmonic injection at two strengths
        run_cfg(1, 32768, 0, 0, 32'h0123_4567, 300, TOL, "R6", hits);
        run_cfg(1, 20000, 0, 0, 32'h0345_6789, 150, TOL, "R6", hits);
        run_cfg(2, 32768, 0, 0, 32'h0123_4567, 300, TOL, "R7", hits);
        run_cfg(2, 20000, 0, 0, 32'h0345_6789, 150, TOL, "R7", hits);
        // R8: adaptive term for unity, 0.8 and lagging load angles
        run_cfg(3, 32768, 32767, 0, 32'h0123_4567, 300, TOL, "R8", hits);
        run_cfg(3, 29000, 26214, 19661, 32'h0123_4567, 300, TOL, "R8", hits);
        run_cfg(3, 24000, 19661, -26214, 32'h0345_6789, 150, TOL, "R8", hits);
        // R9: a 90-degree load angle at full index pushes the peaks into saturation
        run_cfg(3, 65535, 0, 32767, 32'h0123_4567, 300, TOL, "R9", hits);
        chk(hits > 0, "R9", hits, 1);
        // R10: zero index gives exact zeros in every mode
        for (int md = 0; md < 4; md++) run_cfg(md, 0, 26214, 19661, 32'h0123_4567, 40, 0, "R10", hits);
        // R11: a finer step through one mode, checked against the same error bound
        run_cfg(1, 32768, 0, 0, 32'h0040_0000, 1100, TOL, "R11", hits);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule